// File: doc/BRIEF.md
# Stack and Status Byte Sequencer

This unit owns the hardware stack and the flag byte of a small 8-bit processor core. The core hands it one request at a time: push or pull a byte or a 16-bit word, save a return address for a subroutine call, restore it for a return, enter a software break, or come back from an interrupt handler. The unit then performs the byte-wide memory traffic for that request, one access per clock, and raises `done` for a single cycle when the result is ready.

The stack lives in one fixed memory page. An 8-bit pointer moves down on pushes and up on pulls, and it wraps modulo 256 inside that page. The seven flags are held in separate fields. They are packed into a byte when the unit pushes them and unpacked when the unit pulls them. The core can also load the flags directly while the unit is idle. After reset the unit fetches the start address from the reset vector without being asked. Opcode decoding, the arithmetic unit and hardware interrupt entry all belong to the surrounding core.

Top module: `stack_status_unit`

## Requirements
- R1: Reset behaviour. While reset is asserted and afterwards, `busy` is 1, `sp` is 0xFF and `status` is 0x30 (only the break flag and the fixed bit are set). After reset is released, the unit reads 0xFFFC (low byte) and then 0xFFFD (high byte). It pulses `done` with `result` holding that vector.
- R2: Push byte, `req_op`=0. The unit writes `req_data[7:0]` to address 0x0100+sp. It then decrements sp modulo 256, so a push at sp=0x00 writes 0x0100 and leaves sp=0xFF.
- R3: Pull byte, `req_op`=2. The unit increments sp modulo 256 and then reads 0x0100+sp. `result` becomes {0x00, byte}. A pull at sp=0xFF reads 0x0100 and leaves sp=0x00.
- R4: Push word, `req_op`=1. The high byte is written first at 0x0100+sp and the low byte second at the next lower address. sp drops by 2.
- R5: Pull word, `req_op`=3. The low byte is taken from the lower address and the high byte from the next address up. `result` = {high, low} and sp rises by 2.
- R6: Call, `req_op`=4, pushes `req_data`−1 as a word. Return, `req_op`=5, pulls a word and gives `result` = word+1.
- R7: Break, `req_op`=6, pushes `req_data`+1 as a word, then pushes the packed status byte. It then reads the low byte of `result` from 0xFFFE and the high byte from 0xFFFF. The break flag is set when it finishes.
- R8: Return from interrupt, `req_op`=7, pulls the status byte first and loads all flags from it. It then pulls a word into `result`.
- R9: Status byte layout: bit0 carry, bit1 zero, bit2 interrupt-disable, bit3 decimal, bit4 break, bit5 always 1, bit6 overflow, bit7 negative.
- R10: While idle, `flags_we` loads the flags from `flags_wdata` using the R9 layout. Bit 5 of the written value has no effect.
- R11: A request, or a `flags_we`, that arrives while `busy` is 1 has no effect. `busy` stays high until `done` pulses; `done` lasts one cycle and coincides with `busy` returning to 0.
- R12: At most one memory access per clock. `mem_we` is 1 only in the cycles that write stack bytes, and pulls and vector reads write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| req_valid | input | 1 | request strobe, taken only when idle |
| req_op | input | 3 | request code (see R2–R8) |
| req_data | input | 16 | byte or word to push, or program counter for call/break |
| flags_we | input | 1 | direct flag load when idle |
| flags_wdata | input | 8 | packed flag byte for direct load |
| mem_addr | output | ADDR_W | memory address |
| mem_wdata | output | 8 | memory write data |
| mem_we | output | 1 | memory write enable |
| mem_rdata | input | 8 | memory read data, valid in the cycle the address is driven |
| busy | output | 1 | a sequence is in progress |
| done | output | 1 | one-cycle strobe when a sequence ends |
| result | output | 16 | pulled byte or word, or vector |
| sp | output | 8 | stack pointer |
| status | output | 8 | packed status byte |

## Verification
A stack pointer that is off by one shows up at the first write that follows, as a byte at the wrong page address. It also shows up when that byte is pulled back, as a mismatched `result`. Either of these is visible within a few cycles of `done`. A wrong sequencer step shows as a missing or extra write, or as the bytes of a word in swapped order, in the cycles just before `done`. A wrong flag field shows in `status` on the cycle after a load, and again in the byte pushed by the next break.

// File: rtl/ssu_pkg.sv
package ssu_pkg;

   typedef enum logic [2:0] {
      OP_PUSHB = 3'd0,
      OP_PUSHW = 3'd1,
      OP_PULLB = 3'd2,
      OP_PULLW = 3'd3,
      OP_CALL  = 3'd4,
      OP_RET   = 3'd5,
      OP_BRK   = 3'd6,
      OP_RTI   = 3'd7
   } ssu_op_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_WHI,
      ST_WLO,
      ST_WST,
      ST_VLO,
      ST_VHI,
      ST_RST,
      ST_RLO,
      ST_RHI
   } ssu_state_e;

   typedef struct packed {
      logic n;
      logic v;
      logic b;
      logic d;
      logic i;
      logic z;
      logic c;
   } ssu_flags_t;

   function automatic logic [7:0] flags_pack(input ssu_flags_t f);
      return {f.n, f.v, 1'b1, f.b, f.d, f.i, f.z, f.c};
   endfunction

   function automatic ssu_flags_t flags_unpack(input logic [7:0] s);
      ssu_flags_t f;
      f.c = s[0];
      f.z = s[1];
      f.i = s[2];
      f.d = s[3];
      f.b = s[4];
      f.v = s[6];
      f.n = s[7];
      return f;
   endfunction

   function automatic logic is_write_state(input ssu_state_e s);
      return (s == ST_WHI) || (s == ST_WLO) || (s == ST_WST);
   endfunction

   function automatic logic is_pull_state(input ssu_state_e s);
      return (s == ST_RST) || (s == ST_RLO) || (s == ST_RHI);
   endfunction

endpackage

// File: rtl/ssu_seq.sv
module ssu_seq
   import ssu_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  ssu_op_e    req_op,
   output ssu_state_e state,
   output ssu_op_e    op_q,
   output logic       vec_brk,
   output logic       busy,
   output logic       done,
   output logic       accept
);

   ssu_state_e first_st;
   ssu_state_e nxt;

   assign busy   = (state != ST_IDLE);
   assign accept = req_valid && !busy;

   always_comb begin
      case (req_op)
         OP_PUSHB:                   first_st = ST_WLO;
         OP_PUSHW, OP_CALL, OP_BRK:  first_st = ST_WHI;
         OP_RTI:                     first_st = ST_RST;
         default:                    first_st = ST_RLO;
      endcase
   end

   always_comb begin
      case (state)
         ST_IDLE: nxt = accept ? first_st : ST_IDLE;
         ST_WHI:  nxt = ST_WLO;
         ST_WLO:  nxt = (op_q == OP_BRK) ? ST_WST : ST_IDLE;
         ST_WST:  nxt = ST_VLO;
         ST_VLO:  nxt = ST_VHI;
         ST_RST:  nxt = ST_RLO;
         ST_RLO:  nxt = (op_q == OP_PULLB) ? ST_IDLE : ST_RHI;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_VLO;
         op_q    <= OP_PUSHB;
         vec_brk <= 1'b0;
         done    <= 1'b0;
      end else begin
         state <= nxt;
         done  <= busy && (nxt == ST_IDLE);
         if (accept) begin
            op_q    <= req_op;
            vec_brk <= (req_op == OP_BRK);
         end
      end
   end

endmodule

// File: rtl/ssu_stack_ptr.sv
module ssu_stack_ptr
   import ssu_pkg::*;
#(
   parameter int                  ADDR_W     = 16,
   parameter logic [ADDR_W-9:0]   STACK_PAGE = 1,
   parameter logic [ADDR_W-1:0]   VEC_RESET  = 16'hFFFC,
   parameter logic [ADDR_W-1:0]   VEC_BREAK  = 16'hFFFE,
   parameter logic [7:0]          SP_INIT    = 8'hFF
)(
   input  logic              clk,
   input  logic              rst_n,
   input  ssu_state_e        state,
   input  logic              vec_brk,
   output logic [ADDR_W-1:0] addr,
   output logic [7:0]        sp
);

   logic [7:0]        sp_up;
   logic [ADDR_W-1:0] vec_base;

   assign sp_up    = sp + 8'd1;
   assign vec_base = vec_brk ? VEC_BREAK : VEC_RESET;

   always_comb begin
      if (is_pull_state(state))
         addr = {STACK_PAGE, sp_up};
      else if (state == ST_VLO)
         addr = vec_base;
      else if (state == ST_VHI)
         addr = vec_base + ADDR_W'(1);
      else
         addr = {STACK_PAGE, sp};
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         sp <= SP_INIT;
      else if (is_write_state(state))
         sp <= sp - 8'd1;
      else if (is_pull_state(state))
         sp <= sp_up;
   end

endmodule

// File: rtl/ssu_status.sv
module ssu_status
   import ssu_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       host_we,
   input  logic [7:0] host_byte,
   input  logic       pull_we,
   input  logic [7:0] pull_byte,
   input  logic       set_brk,
   output logic [7:0] status_byte
);

   ssu_flags_t flags;

   assign status_byte = flags_pack(flags);

   always_ff @(posedge clk) begin
      if (!rst_n)
         flags <= '{b: 1'b1, default: 1'b0};
      else if (pull_we)
         flags <= flags_unpack(pull_byte);
      else if (set_brk)
         flags.b <= 1'b1;
      else if (host_we)
         flags <= flags_unpack(host_byte);
   end

endmodule

// File: rtl/stack_status_unit.sv
module stack_status_unit
   import ssu_pkg::*;
#(
   parameter int                  ADDR_W     = 16,
   parameter logic [ADDR_W-9:0]   STACK_PAGE = 1,
   parameter logic [ADDR_W-1:0]   VEC_RESET  = 16'hFFFC,
   parameter logic [ADDR_W-1:0]   VEC_BREAK  = 16'hFFFE,
   parameter logic [7:0]          SP_INIT    = 8'hFF
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_op,
   input  logic [15:0]       req_data,
   input  logic              flags_we,
   input  logic [7:0]        flags_wdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   output logic              mem_we,
   input  logic [7:0]        mem_rdata,
   output logic              busy,
   output logic              done,
   output logic [15:0]       result,
   output logic [7:0]        sp,
   output logic [7:0]        status
);

   localparam int WORD_W = 16;

   generate
      if (ADDR_W < 9 || ADDR_W > 32) begin : g_bad_addr_w
         $error("stack_status_unit: ADDR_W must be within 9..32");
      end
      if (VEC_RESET[0] || VEC_BREAK[0]) begin : g_bad_vec
         $error("stack_status_unit: vectors must be even addresses");
      end
   endgenerate

   ssu_state_e        state;
   ssu_op_e           op_q;
   logic              vec_brk;
   logic              accept;
   logic [WORD_W-1:0] wd;
   ssu_op_e           op_in;

   assign op_in = ssu_op_e'(req_op);

   ssu_seq u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_valid(req_valid),
      .req_op  (op_in),
      .state   (state),
      .op_q    (op_q),
      .vec_brk (vec_brk),
      .busy    (busy),
      .done    (done),
      .accept  (accept)
   );

   ssu_stack_ptr #(
      .ADDR_W    (ADDR_W),
      .STACK_PAGE(STACK_PAGE),
      .VEC_RESET (VEC_RESET),
      .VEC_BREAK (VEC_BREAK),
      .SP_INIT   (SP_INIT)
   ) u_sp (
      .clk    (clk),
      .rst_n  (rst_n),
      .state  (state),
      .vec_brk(vec_brk),
      .addr   (mem_addr),
      .sp     (sp)
   );

   ssu_status u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_we    (flags_we && !busy),
      .host_byte  (flags_wdata),
      .pull_we    (state == ST_RST),
      .pull_byte  (mem_rdata),
      .set_brk    ((state == ST_VHI) && (op_q == OP_BRK) && vec_brk),
      .status_byte(status)
   );

   assign mem_we = is_write_state(state);

   always_comb begin
      case (state)
         ST_WHI:  mem_wdata = wd[15:8];
         ST_WLO:  mem_wdata = wd[7:0];
         ST_WST:  mem_wdata = status;
         default: mem_wdata = 8'h00;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wd <= '0;
      end else if (accept) begin
         case (op_in)
            OP_CALL:  wd <= req_data - WORD_W'(1);
            OP_BRK:   wd <= req_data + WORD_W'(1);
            OP_PUSHB: wd <= {8'h00, req_data[7:0]};
            default:  wd <= req_data;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result <= '0;
      end else begin
         case (state)
            ST_RLO, ST_VLO: result <= {8'h00, mem_rdata};
            ST_RHI:         result <= {mem_rdata, result[7:0]}
                                      + WORD_W'(op_q == OP_RET);
            ST_VHI:         result <= {mem_rdata, result[7:0]};
            default:        result <= result;
         endcase
      end
   end

endmodule

// File: rtl/ssu_chk.sv
module ssu_chk #(
   parameter int ADDR_W = 16
)(
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [7:0]        sp,
   input logic [7:0]        status
);

   // R9: the fixed bit of the packed byte
   p_status_bit5_r9: assert property (@(posedge clk) disable iff (!rst_n)
      status[5] == 1'b1);

   // R12: writes happen only inside a sequence
   p_write_in_seq_r12: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> busy);

   // R2: each written byte lands in the stack page at the pointer, which then drops
   p_push_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_addr[7:0] == sp));
   p_push_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> (sp == $past(sp) - 8'd1));

   // R11: idle cycles leave the pointer untouched
   p_idle_sp_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(sp));

   // R11: done is a single-cycle strobe that coincides with leaving busy
   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   p_busy_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

endmodule

bind stack_status_unit ssu_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .busy    (busy),
   .done    (done),
   .mem_we  (mem_we),
   .mem_addr(mem_addr),
   .sp      (sp),
   .status  (status)
);

// File: tb/stack_status_unit_test.sv
module stack_status_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_op = 3'd0;
   logic [15:0] req_data = 16'h0000;
   logic        flags_we = 1'b0;
   logic [7:0]  flags_wdata = 8'h00;
   logic [15:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic        mem_we;
   logic [7:0]  mem_rdata;
   logic        busy;
   logic        done;
   logic [15:0] result;
   logic [7:0]  sp;
   logic [7:0]  status;

   int n_chk = 0;
   int n_bad = 0;

   logic [7:0]  ram [0:511];
   logic [15:0] wlog_a [0:15];
   logic [7:0]  wlog_d [0:15];
   int          wcnt = 0;

   always #5 clk = ~clk;

   stack_status_unit uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_data(req_data), .flags_we(flags_we), .flags_wdata(flags_wdata),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
      .mem_rdata(mem_rdata), .busy(busy), .done(done), .result(result),
      .sp(sp), .status(status)
   );

   always_comb begin
      case (mem_addr)
         16'hFFFC: mem_rdata = 8'h34;
         16'hFFFD: mem_rdata = 8'h12;
         16'hFFFE: mem_rdata = 8'hCD;
         16'hFFFF: mem_rdata = 8'hAB;
         default:  mem_rdata = (mem_addr < 16'd512) ? ram[mem_addr[8:0]] : 8'hEE;
      endcase
   end

   always @(posedge clk) begin
      if (mem_we) begin
         if (mem_addr < 16'd512) ram[mem_addr[8:0]] <= mem_wdata;
         wlog_a[wcnt[3:0]] <= mem_addr;
         wlog_d[wcnt[3:0]] <= mem_wdata;
         wcnt <= wcnt + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic wait_done();
      int n = 0;
      while (!done && n < 20) begin
         @(negedge clk);
         n++;
      end
      chk(done == 1'b1, "R11", "done strobe seen", done, 1);
   endtask

   task automatic issue(input logic [2:0] op, input logic [15:0] d);
      req_valid = 1'b1;
      req_op    = op;
      req_data  = d;
      @(negedge clk);
      req_valid = 1'b0;
      wait_done();
   endtask

   task automatic load_flags(input logic [7:0] f);
      flags_we    = 1'b1;
      flags_wdata = f;
      @(negedge clk);
      flags_we    = 1'b0;
   endtask

   task automatic t_reset();
      chk(busy == 1'b1, "R1", "busy in reset", busy, 1);
      chk(sp == 8'hFF, "R1", "sp in reset", sp, 8'hFF);
      chk(status == 8'h30, "R1", "status in reset", status, 8'h30);
      @(negedge clk);
      rst_n = 1'b1;
      wait_done();
      chk(result == 16'h1234, "R1", "reset vector", result, 16'h1234);
      chk(busy == 1'b0, "R11", "busy cleared with done", busy, 0);
      @(negedge clk);
      chk(done == 1'b0, "R11", "done one cycle", done, 0);
   endtask

   task automatic t_push_byte();
      int w0 = wcnt;
      issue(3'd0, 16'h775A);
      chk(ram[9'h1FF] == 8'h5A, "R2", "byte at 0x01FF", ram[9'h1FF], 8'h5A);
      chk(sp == 8'hFE, "R2", "sp after push", sp, 8'hFE);
      chk(wcnt - w0 == 1, "R12", "write count", wcnt - w0, 1);
   endtask

   task automatic t_push_word();
      int w0 = wcnt;
      issue(3'd1, 16'hBEEF);
      chk(wlog_a[w0[3:0]] == 16'h01FE && wlog_d[w0[3:0]] == 8'hBE, "R4",
          "first write high byte at 0x01FE", wlog_a[w0[3:0]], 16'h01FE);
      chk(ram[9'h1FD] == 8'hEF, "R4", "low byte at 0x01FD", ram[9'h1FD], 8'hEF);
      chk(sp == 8'hFC, "R4", "sp after word push", sp, 8'hFC);
   endtask

   task automatic t_pull_word();
      int w0 = wcnt;
      issue(3'd3, 16'h0000);
      chk(result == 16'hBEEF, "R5", "pulled word", result, 16'hBEEF);
      chk(sp == 8'hFE, "R5", "sp after word pull", sp, 8'hFE);
      chk(wcnt == w0, "R12", "pull writes nothing", wcnt - w0, 0);
   endtask

   task automatic t_pull_byte();
      issue(3'd2, 16'h0000);
      chk(result == 16'h005A, "R3", "pulled byte", result, 16'h005A);
      chk(sp == 8'hFF, "R3", "sp after pull", sp, 8'hFF);
   endtask

   task automatic t_wrap();
      ram[9'h100] = 8'h77;
      issue(3'd2, 16'h0000);
      chk(result == 16'h0077, "R3", "pull wraps to 0x0100", result, 16'h0077);
      chk(sp == 8'h00, "R3", "sp wraps to 00", sp, 8'h00);
      issue(3'd0, 16'h0033);
      chk(ram[9'h100] == 8'h33, "R2", "push at sp 00 hits 0x0100", ram[9'h100], 8'h33);
      chk(sp == 8'hFF, "R2", "sp wraps to FF", sp, 8'hFF);
   endtask

   task automatic t_call_ret();
      issue(3'd4, 16'h2003);
      chk(ram[9'h1FF] == 8'h20 && ram[9'h1FE] == 8'h02, "R6", "call pushes pc-1",
          {ram[9'h1FF], ram[9'h1FE]}, 16'h2002);
      chk(sp == 8'hFD, "R6", "sp after call", sp, 8'hFD);
      issue(3'd5, 16'h0000);
      chk(result == 16'h2003, "R6", "return gives word+1", result, 16'h2003);
      chk(sp == 8'hFF, "R6", "sp after return", sp, 8'hFF);
   endtask

   task automatic t_flags();
      load_flags(8'hC3);
      chk(status == 8'hE3, "R10", "direct flag load", status, 8'hE3);
      load_flags(8'h00);
      chk(status == 8'h20, "R9", "bit5 stays set", status, 8'h20);
      load_flags(8'hC3);
   endtask

   task automatic t_brk();
      int w0 = wcnt;
      issue(3'd6, 16'h3000);
      chk(wlog_a[w0[3:0]] == 16'h01FF && wlog_d[w0[3:0]] == 8'h30, "R7",
          "first write high of pc+1", wlog_d[w0[3:0]], 8'h30);
      chk(wlog_a[w0[3:0] + 4'd1] == 16'h01FE && wlog_d[w0[3:0] + 4'd1] == 8'h01, "R7",
          "second write low of pc+1", wlog_d[w0[3:0] + 4'd1], 8'h01);
      chk(wlog_a[w0[3:0] + 4'd2] == 16'h01FD && wlog_d[w0[3:0] + 4'd2] == 8'hE3, "R9",
          "third write packed status", wlog_d[w0[3:0] + 4'd2], 8'hE3);
      chk(wcnt - w0 == 3, "R12", "break write count", wcnt - w0, 3);
      chk(result == 16'hABCD, "R7", "break vector", result, 16'hABCD);
      chk(status == 8'hF3, "R7", "break flag set", status, 8'hF3);
      chk(sp == 8'hFC, "R7", "sp after break", sp, 8'hFC);
   endtask

   task automatic t_rti();
      load_flags(8'h1C);
      chk(status == 8'h3C, "R10", "flags before return", status, 8'h3C);
      issue(3'd7, 16'h0000);
      chk(status == 8'hE3, "R8", "flags from pulled byte", status, 8'hE3);
      chk(result == 16'h3001, "R8", "pulled return word", result, 16'h3001);
      chk(sp == 8'hFF, "R8", "sp after return from interrupt", sp, 8'hFF);
   endtask

   task automatic t_busy_ignore();
      int  w0 = wcnt;
      bit  held = 1'b1;
      logic [7:0] st0 = status;
      req_valid = 1'b1;
      req_op    = 3'd1;
      req_data  = 16'h1111;
      @(negedge clk);
      req_op      = 3'd0;
      req_data    = 16'h0099;
      flags_we    = 1'b1;
      flags_wdata = 8'hFF;
      held = held && busy;
      @(negedge clk);
      req_valid = 1'b0;
      flags_we  = 1'b0;
      if (!done) held = held && busy;
      wait_done();
      chk(held, "R11", "busy held until done", held, 1);
      chk(wcnt - w0 == 2, "R11", "request while busy ignored", wcnt - w0, 2);
      chk(sp == 8'hFD, "R11", "sp after ignored request", sp, 8'hFD);
      chk(status == st0, "R11", "flag write while busy ignored", status, st0);
      @(negedge clk);
      chk(busy == 1'b0 && sp == 8'hFD, "R11", "no late start", sp, 8'hFD);
      issue(3'd3, 16'h0000);
      chk(result == 16'h1111, "R5", "word after ignore test", result, 16'h1111);
   endtask

   initial begin
      for (int i = 0; i < 512; i++) ram[i] = 8'h00;
      @(negedge clk);
      @(negedge clk);
      t_reset();
      t_push_byte();
      t_push_word();
      t_pull_word();
      t_pull_byte();
      t_wrap();
      t_call_ret();
      t_flags();
      t_brk();
      t_rti();
      t_busy_ignore();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule